// File: doc/BRIEF.md
# Power-of-Two Decimator with Sliding Averager

This block is the second rate-reduction stage of an oversampled measurement path. It takes signed samples, each marked by a valid strobe, and reduces their rate by a programmable power of two, 2^E, where E runs from 0 to 15. The reduction uses a first-order integrator/comb pair. Each decimated result is the floor-rounded mean of the 2^E samples in its block. With E = 0 every sample passes through unchanged.

A selectable stage follows the decimator. When `avg_sel` is high, the block forms a sliding mean over the last L decimated results, where L is any whole number from 1 to 15. When `avg_sel` is low, the decimated result goes straight to the output. In that case the averager keeps running in the background, but its result is not used. The averager divides by L with a small table of reciprocals and one multiply, so no divider is needed.

After reset, and after any change of L, the averager stays silent until its window holds L fresh results. A new exponent or a new length takes effect from the clock after it appears. The stage that sees the change discards the sample that arrives in that cycle.

Top module: `dec_avg_top`

## Requirements
- R1: While `rst_n` is low, and after its release until a result is ready, `out_valid` stays low.
- R2: The decimator produces exactly one result for every 2^E accepted samples, where E is `dec_exp` (0..15). Only cycles with `in_valid` high are counted.
- R3: A decimated result equals floor(S / 2^E), where S is the signed sum of its block's samples, in 16-bit two's complement. With `avg_sel` low, this result is on `out_data` with `out_valid` high one clock after the edge that accepted the block's last sample.
- R4: With E = 0 and `avg_sel` low, each accepted sample appears unchanged on `out_data` one clock after it is accepted.
- R5: A change of `dec_exp` discards the partial block and restarts the count. A sample accepted in the cycle the change appears is discarded.
- R6: With `avg_sel` high, the output equals floor(T / L), where T is the sum of the most recent L decimated results. It is valid one clock after the decimated result, which is two clocks after the block's last input sample.
- R7: After reset or a change of `avg_len`, the first L-1 decimated results give no averaged output, and each later result gives one. A length change empties the window, and a decimated result arriving in the cycle of the change is dropped.
- R8: An `avg_len` of 0 acts as a length of 1.
- R9: With `avg_sel` low, the output is the decimated result regardless of `avg_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| dec_exp | input | 4 | Decimation exponent E; ratio is 2^E |
| avg_len | input | 4 | Averaging length L (0 treated as 1) |
| avg_sel | input | 1 | 1: averaged output, 0: decimator output |
| out_valid | output | 1 | Output strobe |
| out_data | output | 16 | Signed output word |

## Verification
The assertions assume two things about the inputs. First, whenever `in_valid` is high, `in_data` carries a known value. Second, `dec_exp` and `avg_len` are driven, not left floating, so the change detectors compare known values. The stimulus changes the exponent and the length only during reset or in idle cycles, except for the directed case that deliberately drops a sample on a change. It also holds `avg_sel` steady for a whole run, so every output strobe comes from a single path.

// File: rtl/dec_avg_pkg.sv
package dec_avg_pkg;

  // Smallest m with m*l >= 2^k; floor(n*m / 2^k) == floor(n / l)
  // for every 0 <= n < 2^(k - ceil(log2 l)).
  function automatic longint unsigned recip_ceil(input int unsigned l, input int unsigned k);
    longint unsigned one_k;
    one_k = 64'(1) << k;
    return (one_k + 64'(l) - 64'(1)) / 64'(l);
  endfunction

  // Averaging length with the zero code mapped to one.
  function automatic int unsigned len_eff(input int unsigned l);
    return (l == 0) ? 1 : l;
  endfunction

endpackage

// File: rtl/dec_cic_pow2.sv
module dec_cic_pow2 #(
  parameter int DIN_W = 16,
  parameter int EXP_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [DIN_W-1:0] in_data,
  input  logic [EXP_W-1:0]        exp_i,
  output logic                    dec_valid,
  output logic signed [DIN_W-1:0] dec_data
);
  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int ACC_W   = DIN_W + MAX_EXP;
  localparam int CNT_W   = MAX_EXP;

  logic signed [ACC_W-1:0] integ_q, ref_q, integ_nxt, comb;
  logic [CNT_W-1:0]        cnt_q;
  logic [EXP_W-1:0]        exp_q;

  function automatic logic [CNT_W-1:0] ratio_mask(input logic [EXP_W-1:0] e);
    return ~({CNT_W{1'b1}} << e);
  endfunction

  function automatic logic signed [DIN_W-1:0] norm_shift(input logic signed [ACC_W-1:0] s,
                                                         input logic [EXP_W-1:0] e);
    logic signed [ACC_W-1:0] t;
    t = s >>> e;
    return t[DIN_W-1:0];
  endfunction

  // Named events for the checks below.
  wire exp_chg  = (exp_i != exp_q);
  wire take     = in_valid & ~exp_chg;
  wire blk_end  = take & (cnt_q == ratio_mask(exp_q));
  wire unit_evt = take & (exp_q == '0);

  always_comb begin
    integ_nxt = integ_q + ACC_W'(in_data);
    comb      = integ_nxt - ref_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q   <= '0;
      ref_q     <= '0;
      cnt_q     <= '0;
      exp_q     <= '0;
      dec_valid <= 1'b0;
      dec_data  <= '0;
    end else if (exp_chg) begin
      exp_q     <= exp_i;
      integ_q   <= '0;
      ref_q     <= '0;
      cnt_q     <= '0;
      dec_valid <= 1'b0;
    end else begin
      dec_valid <= blk_end;
      if (take) begin
        integ_q <= integ_nxt;
        cnt_q   <= blk_end ? '0 : cnt_q + CNT_W'(1);
        if (blk_end) begin
          ref_q    <= integ_nxt;
          dec_data <= norm_shift(comb, exp_q);
        end
      end
    end
  end

  a_r2_result_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid));
  a_r4_unit_ratio_passes: assert property (@(posedge clk) disable iff (!rst_n)
    unit_evt |=> (dec_valid && dec_data == $past(in_data)));
  a_r5_change_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    exp_chg |=> !dec_valid);

endmodule

// File: rtl/dec_mov_avg.sv
module dec_mov_avg #(
  parameter int DIN_W = 16,
  parameter int LEN_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [DIN_W-1:0] in_data,
  input  logic [LEN_W-1:0]        len_i,
  output logic                    avg_valid,
  output logic signed [DIN_W-1:0] avg_data
);
  import dec_avg_pkg::*;

  localparam int MAX_LEN = (1 << LEN_W) - 1;
  localparam int SUM_W   = DIN_W + LEN_W;
  localparam int K       = SUM_W + LEN_W;
  localparam int RCP_W   = K + 1;
  localparam int PRD_W   = SUM_W + RCP_W;

  logic signed [DIN_W-1:0] hist [0:MAX_LEN-1];
  logic signed [SUM_W-1:0] sum_q, sum_nxt;
  logic [LEN_W-1:0]        fill_q, fill_nxt, len_q, leff;
  logic [RCP_W-1:0]        rcp_tab [0:MAX_LEN];
  logic signed [DIN_W-1:0] drop, quot;
  logic [SUM_W-1:0]        mag, q_mag;
  logic [PRD_W-1:0]        prod;
  logic                    neg;

  for (genvar g = 0; g <= MAX_LEN; g++) begin : g_rcp
    assign rcp_tab[g] = RCP_W'(recip_ceil(len_eff(g), K));
  end

  wire len_chg  = (len_i != len_q);
  wire take     = in_valid & ~len_chg;
  wire win_full = (fill_q == leff);

  always_comb begin
    leff     = LEN_W'(len_eff(32'(len_q)));
    drop     = win_full ? hist[leff - LEN_W'(1)] : '0;
    sum_nxt  = sum_q + SUM_W'(in_data) - SUM_W'(drop);
    fill_nxt = win_full ? fill_q : fill_q + LEN_W'(1);
    neg      = sum_nxt[SUM_W-1];
    mag      = neg ? (SUM_W'(-sum_nxt) + SUM_W'(leff - LEN_W'(1))) : SUM_W'(sum_nxt);
    prod     = PRD_W'(mag) * PRD_W'(rcp_tab[leff]);
    q_mag    = SUM_W'(prod >> K);
    quot     = neg ? DIN_W'(-q_mag) : DIN_W'(q_mag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_LEN; i++) hist[i] <= '0;
      sum_q     <= '0;
      fill_q    <= '0;
      len_q     <= '0;
      avg_valid <= 1'b0;
      avg_data  <= '0;
    end else if (len_chg) begin
      len_q     <= len_i;
      sum_q     <= '0;
      fill_q    <= '0;
      avg_valid <= 1'b0;
    end else begin
      avg_valid <= take & (fill_nxt == leff);
      if (take) begin
        hist[0] <= in_data;
        for (int i = 1; i < MAX_LEN; i++) hist[i] <= hist[i-1];
        sum_q    <= sum_nxt;
        fill_q   <= fill_nxt;
        avg_data <= quot;
      end
    end
  end

  a_r6_avg_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |-> $past(in_valid));
  a_r7_window_full: assert property (@(posedge clk) disable iff (!rst_n)
    avg_valid |-> (fill_q == leff));
  a_r7_len_change_drops: assert property (@(posedge clk) disable iff (!rst_n)
    len_chg |=> !avg_valid);
  a_r8_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= leff);

endmodule

// File: rtl/dec_avg_top.sv
module dec_avg_top #(
  parameter int DIN_W = 16,
  parameter int EXP_W = 4,
  parameter int LEN_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [DIN_W-1:0] in_data,
  input  logic [EXP_W-1:0]        dec_exp,
  input  logic [LEN_W-1:0]        avg_len,
  input  logic                    avg_sel,
  output logic                    out_valid,
  output logic signed [DIN_W-1:0] out_data
);
  logic                    dec_v, avg_v;
  logic signed [DIN_W-1:0] dec_d, avg_d;

  dec_cic_pow2 #(.DIN_W(DIN_W), .EXP_W(EXP_W)) u_cic (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .exp_i(dec_exp), .dec_valid(dec_v), .dec_data(dec_d)
  );

  dec_mov_avg #(.DIN_W(DIN_W), .LEN_W(LEN_W)) u_avg (
    .clk(clk), .rst_n(rst_n), .in_valid(dec_v), .in_data(dec_d),
    .len_i(avg_len), .avg_valid(avg_v), .avg_data(avg_d)
  );

  assign out_valid = avg_sel ? avg_v : dec_v;
  assign out_data  = avg_sel ? avg_d : dec_d;

endmodule

// File: tb/sim_dec_avg_top.sv
module sim_dec_avg_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic [3:0] dec_exp = '0;
  logic [3:0] avg_len = '0;
  logic avg_sel = 1'b0;
  logic out_valid;
  logic signed [15:0] out_data;

  int checks = 0;
  int errors = 0;
  int gcnt = 0;
  int ecnt = 0;
  longint got [0:511];
  longint expq [0:511];
  bit done = 1'b0;

  always #5 clk = ~clk;

  dec_avg_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .dec_exp(dec_exp), .avg_len(avg_len), .avg_sel(avg_sel),
    .out_valid(out_valid), .out_data(out_data)
  );

  // exp, len, sel, pattern, samples, gap
  localparam int VEC [0:7][0:5] = '{
    '{0, 1, 0, 0, 40, 0},
    '{2, 3, 1, 0, 200, 1},
    '{4, 15, 1, 0, 320, 0},
    '{3, 0, 1, 3, 80, 0},
    '{1, 7, 0, 2, 50, 1},
    '{15, 1, 0, 3, 65536, 0},
    '{5, 5, 1, 3, 384, 0},
    '{0, 15, 1, 0, 60, 1}
  };

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (gcnt < 512) got[gcnt] = longint'(out_data);
      gcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint fdiv(input longint a, input longint b);
    longint q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  function automatic int gen(input int pat, input int i);
    case (pat)
      0: return ((i * 7919 + 12345) % 65536) - 32768;
      1: return 32767;
      2: return -32768;
      default: return (i % 2 == 1) ? -32768 : 32767;
    endcase
  endfunction

  task automatic push_exp(input longint v);
    if (ecnt < 512) expq[ecnt] = v;
    ecnt++;
  endtask

  task automatic do_reset(input int e, input int l, input bit s);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    dec_exp = 4'(e); avg_len = 4'(l); avg_sel = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    gcnt = 0; ecnt = 0;
  endtask

  task automatic send(input int x);
    in_valid = 1'b1; in_data = 16'(x);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_vec(input int v);
    int e, l, s, pat, n, gap, leff, mn, mf;
    longint macc, d, tsum;
    longint mh [0:14];
    string tag;
    e = VEC[v][0]; l = VEC[v][1]; s = VEC[v][2];
    pat = VEC[v][3]; n = VEC[v][4]; gap = VEC[v][5];
    leff = (l == 0) ? 1 : l;
    do_reset(e, l, s[0]);
    macc = 0; mn = 0; mf = 0;
    for (int k = 0; k < 15; k++) mh[k] = 0;
    for (int i = 0; i < n; i++) begin
      int x;
      x = gen(pat, i);
      send(x);
      if (gap != 0 && i % 3 == 2) @(negedge clk);
      macc += x; mn++;
      if (mn == (1 << e)) begin
        d = macc >>> e;
        macc = 0; mn = 0;
        if (s == 0) push_exp(d);
        else begin
          for (int k = 14; k > 0; k--) mh[k] = mh[k-1];
          mh[0] = d;
          if (mf < leff) mf++;
          if (mf == leff) begin
            tsum = 0;
            for (int k = 0; k < leff; k++) tsum += mh[k];
            push_exp(fdiv(tsum, leff));
          end
        end
      end
    end
    repeat (5) @(negedge clk);
    if (s == 0) tag = (v == 4) ? "R9" : "R3";
    else tag = (l == 0) ? "R8" : "R6";
    chk(gcnt == ecnt, (s == 0) ? "R2 count" : "R7 count", gcnt, ecnt);
    for (int k = 0; k < ecnt && k < gcnt && k < 512; k++)
      chk(got[k] == expq[k], tag, got[k], expq[k]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1 in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 after release", out_valid, 0);

    for (int v = 0; v < 8; v++) run_vec(v);

    // R4: unit ratio latency
    do_reset(0, 1, 1'b0);
    in_valid = 1'b1; in_data = -16'sd1234;
    @(negedge clk);
    chk(out_valid == 1'b1, "R4 valid", out_valid, 1);
    chk(out_data == -16'sd1234, "R4 data", out_data, -1234);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 single", out_valid, 0);

    // R6: averaged path has one extra clock
    do_reset(0, 1, 1'b1);
    in_valid = 1'b1; in_data = 16'sd777;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R6 early", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R6 valid", out_valid, 1);
    chk(out_data == 16'sd777, "R6 data", out_data, 777);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 single", out_valid, 0);

    // R5: exponent change drops partial block and the sample of that cycle
    do_reset(2, 1, 1'b0);
    send(10); send(20);
    dec_exp = 4'd1;
    send(1000);
    send(30); send(41);
    repeat (3) @(negedge clk);
    chk(gcnt == 1, "R5 count", gcnt, 1);
    chk(got[0] == 35, "R5 value", got[0], 35);

    // R7: length change empties window; negative floor
    do_reset(0, 3, 1'b1);
    send(3); send(6); send(9);
    @(negedge clk);
    avg_len = 4'd2;
    repeat (2) @(negedge clk);
    send(5);
    send(8);
    send(-9);
    repeat (3) @(negedge clk);
    chk(gcnt == 3, "R7 count", gcnt, 3);
    chk(got[0] == 6, "R7 first", got[0], 6);
    chk(got[1] == 6, "R7 refill", got[1], 6);
    chk(got[2] == -1, "R7 floor", got[2], -1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule